// File: doc/BRIEF.md
# Two-Level Interrupt Priority Resolver

This block chooses which of seven interrupt sources an 8051-style core services next. Each source has one programmable priority bit that splits the sources into a high and a low group. Software reaches these bits through two special-function registers on a plain write/read port. Every cycle the block combines the per-source event flags and masks them with an external enable vector. It then selects the winner and presents a registered valid flag together with a 3-bit source index.

Any pending source in the high group beats every pending source in the low group. Within one group, the fixed natural order decides. In that order external 0 ranks first, followed by timer 0, external 1, timer 1, serial and timer 2, and the I2C source ranks last. The serial source merges two flags, as does timer 2. The I2C source merges four event flags. Nesting, stack handling and vector fetch belong to the core around the block.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset both priority registers read 00h, and `irq_valid` is 0 until an enabled request arrives.
- R2: The register at address B8h holds six priority bits in this order: bit0 external 0, bit1 timer 0, bit2 external 1, bit3 timer 1, bit4 serial, bit5 timer 2. Bits 7:6 always read 0. Writes take effect at the rising clock edge, and reads are combinational.
- R3: The register at address B9h holds the I2C priority in bit0, and bits 7:1 always read 0. Reads from any other address return 00h. Writes to any other address change neither register.
- R4: The source index encodes external 0 as 0, timer 0 as 1, external 1 as 2, timer 1 as 3, serial as 4, timer 2 as 5 and I2C as 6. The serial source is pending when its receive or transmit flag is set. Timer 2 is pending when its overflow or external flag is set.
- R5: The I2C source is pending when any of its four flags is set: receive, transmit, transfer finished or no-acknowledge.
- R6: A source competes only while its bit in `src_enable` (bit i for index i) is 1.
- R7: A pending source whose priority bit is 1 always wins over every pending source whose priority bit is 0.
- R8: Among pending sources of the same priority level, the lowest index wins.
- R9: `irq_valid` is 0 when no enabled source is pending.
- R10: `irq_valid` and `irq_index` are registered. They reflect the requests, enables and priority bits present just before the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| ext0_flag | input | 1 | External 0 request |
| tmr0_flag | input | 1 | Timer 0 overflow request |
| ext1_flag | input | 1 | External 1 request |
| tmr1_flag | input | 1 | Timer 1 overflow request |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| tmr2_ovf_flag | input | 1 | Timer 2 overflow flag |
| tmr2_ext_flag | input | 1 | Timer 2 external flag |
| i2c_rx_flag | input | 1 | I2C receive flag |
| i2c_tx_flag | input | 1 | I2C transmit flag |
| i2c_done_flag | input | 1 | I2C transfer-finished flag |
| i2c_nack_flag | input | 1 | I2C no-acknowledge flag |
| src_enable | input | 7 | Per-source enable mask, bit i for index i |
| irq_valid | output | 1 | A winning source exists |
| irq_index | output | 3 | Index of the winning source |

## Verification
The assertions assume that all request, enable and SFR inputs are known (no X) and stable around each rising edge once the internal reset has been released. They also assume that the synchronised reset gates every temporal check. The stimulus drives every input at the falling edge only. It holds reset for several cycles and waits for the synchroniser to release before any check. It sweeps all 128 priority settings against all 128 request patterns, rotating through the alternative merged flags. It then sweeps all 128 enable masks with every flag raised.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  localparam int NUM_SRC  = 7;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int SFR_W    = 8;
  localparam int BASE_PRIO_BITS = 6;

  localparam logic [SFR_W-1:0] ADDR_PRIO_BASE = 8'hB8;
  localparam logic [SFR_W-1:0] ADDR_PRIO_EXT  = 8'hB9;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5,
    SRC_I2C  = 3'd6
  } src_e;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_level_pkg::*;
#(
  parameter int W        = SFR_W,
  parameter int BASE_N   = BASE_PRIO_BITS,
  parameter int EXT_N    = NUM_SRC - BASE_PRIO_BITS,
  parameter logic [W-1:0] A_BASE = ADDR_PRIO_BASE,
  parameter logic [W-1:0] A_EXT  = ADDR_PRIO_EXT
) (
  input  logic                    clk,
  input  logic                    rst_core_n,
  input  logic                    we,
  input  logic [W-1:0]            addr,
  input  logic [W-1:0]            wdata,
  output logic [W-1:0]            rdata,
  output logic [BASE_N+EXT_N-1:0] prio
);
  localparam logic [W-1:0] MASK_BASE = W'((1 << BASE_N) - 1);
  localparam logic [W-1:0] MASK_EXT  = W'((1 << EXT_N) - 1);

  logic [W-1:0] base_q, base_d;
  logic [W-1:0] ext_q, ext_d;
  logic         base_ce, ext_ce;

  always_comb begin
    base_ce = we && (addr == A_BASE);
    ext_ce  = we && (addr == A_EXT);
    base_d  = wdata & MASK_BASE;
    ext_d   = wdata & MASK_EXT;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      base_q <= '0;
      ext_q  <= '0;
    end else begin
      if (base_ce) base_q <= base_d;
      if (ext_ce)  ext_q  <= ext_d;
    end
  end

  always_comb begin
    if (addr == A_BASE)      rdata = base_q;
    else if (addr == A_EXT)  rdata = ext_q;
    else                     rdata = '0;
    prio = {ext_q[EXT_N-1:0], base_q[BASE_N-1:0]};
  end

  // R2
  base_write_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (we && addr == A_BASE) |=> (prio[BASE_N-1:0] == $past(wdata[BASE_N-1:0])));

  // R3
  ext_write_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (we && addr == A_EXT) |=> (prio[BASE_N+EXT_N-1:BASE_N] == $past(wdata[EXT_N-1:0])));

  // R3
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(we && (addr == A_BASE || addr == A_EXT)) |=> $stable(prio));
endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge
  import irq_level_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         ext0_flag,
  input  logic         tmr0_flag,
  input  logic         ext1_flag,
  input  logic         tmr1_flag,
  input  logic         ser_rx_flag,
  input  logic         ser_tx_flag,
  input  logic         tmr2_ovf_flag,
  input  logic         tmr2_ext_flag,
  input  logic [3:0]   i2c_flags,
  input  logic [N-1:0] enable,
  output logic [N-1:0] pend
);
  logic [N-1:0] raw;

  always_comb begin
    raw           = '0;
    raw[SRC_EXT0] = ext0_flag;
    raw[SRC_TMR0] = tmr0_flag;
    raw[SRC_EXT1] = ext1_flag;
    raw[SRC_TMR1] = tmr1_flag;
    raw[SRC_SER]  = ser_rx_flag | ser_tx_flag;
    raw[SRC_TMR2] = tmr2_ovf_flag | tmr2_ext_flag;
    raw[SRC_I2C]  = |i2c_flags;
    pend          = raw & enable;
  end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
  parameter int W  = 7,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_level_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int IW = IDX_W
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  prio,
  output logic          valid,
  output logic [IW-1:0] idx
);
  localparam int LEVELS = 2;

  logic [LEVELS-1:0]   lvl_found;
  logic [IW-1:0]       lvl_idx [LEVELS];

  generate
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      logic [N-1:0] lvl_vec;
      always_comb lvl_vec = (lv == 1) ? (pend & prio) : (pend & ~prio);
      irq_first_set #(.W(N), .IW(IW)) u_enc (
        .vec   (lvl_vec),
        .found (lvl_found[lv]),
        .idx   (lvl_idx[lv])
      );
    end
  endgenerate

  always_comb begin
    valid = |lvl_found;
    idx   = lvl_found[1] ? lvl_idx[1] : lvl_idx[0];
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_level_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int IW = IDX_W,
  parameter int W  = SFR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sfr_we,
  input  logic [W-1:0]  sfr_addr,
  input  logic [W-1:0]  sfr_wdata,
  output logic [W-1:0]  sfr_rdata,
  input  logic          ext0_flag,
  input  logic          tmr0_flag,
  input  logic          ext1_flag,
  input  logic          tmr1_flag,
  input  logic          ser_rx_flag,
  input  logic          ser_tx_flag,
  input  logic          tmr2_ovf_flag,
  input  logic          tmr2_ext_flag,
  input  logic          i2c_rx_flag,
  input  logic          i2c_tx_flag,
  input  logic          i2c_done_flag,
  input  logic          i2c_nack_flag,
  input  logic [N-1:0]  src_enable,
  output logic          irq_valid,
  output logic [IW-1:0] irq_index
);
  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic [N-1:0]  pend;
  logic [N-1:0]  prio;
  logic          sel_valid;
  logic [IW-1:0] sel_idx;
  logic          valid_q, valid_d;
  logic [IW-1:0] index_q, index_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_core_n = rst_sync_q[1];

  irq_prio_regs #(.W(W), .BASE_N(BASE_PRIO_BITS), .EXT_N(N - BASE_PRIO_BITS)) u_regs (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .we         (sfr_we),
    .addr       (sfr_addr),
    .wdata      (sfr_wdata),
    .rdata      (sfr_rdata),
    .prio       (prio)
  );

  irq_req_merge #(.N(N)) u_merge (
    .ext0_flag     (ext0_flag),
    .tmr0_flag     (tmr0_flag),
    .ext1_flag     (ext1_flag),
    .tmr1_flag     (tmr1_flag),
    .ser_rx_flag   (ser_rx_flag),
    .ser_tx_flag   (ser_tx_flag),
    .tmr2_ovf_flag (tmr2_ovf_flag),
    .tmr2_ext_flag (tmr2_ext_flag),
    .i2c_flags     ({i2c_nack_flag, i2c_done_flag, i2c_tx_flag, i2c_rx_flag}),
    .enable        (src_enable),
    .pend          (pend)
  );

  irq_arbiter #(.N(N), .IW(IW)) u_arb (
    .pend  (pend),
    .prio  (prio),
    .valid (sel_valid),
    .idx   (sel_idx)
  );

  always_comb begin
    valid_d = sel_valid;
    index_d = sel_valid ? sel_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      index_q <= '0;
    end else begin
      valid_q <= valid_d;
      index_q <= index_d;
    end
  end

  always_comb begin
    irq_valid = valid_q;
    irq_index = index_q;
  end

  // R6
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    sel_valid |-> pend[sel_idx]);

  // R7
  level_order_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sel_valid && !prio[sel_idx]) |-> ((pend & prio) == '0));

  // R8
  natural_order_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    sel_valid |-> ((pend & (prio[sel_idx] ? prio : ~prio)
                    & ((N'(1) << sel_idx) - N'(1))) == '0));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pend == '0) |=> !irq_valid);

  // R10
  output_lag_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pend != '0) |=> (irq_valid && irq_index == $past(sel_idx)));
endmodule

// File: tb/irq_level_arbiter_test.sv
`timescale 1ns/1ps
module irq_level_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sfr_we;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       ext0_flag, tmr0_flag, ext1_flag, tmr1_flag;
  logic       ser_rx_flag, ser_tx_flag, tmr2_ovf_flag, tmr2_ext_flag;
  logic       i2c_rx_flag, i2c_tx_flag, i2c_done_flag, i2c_nack_flag;
  logic [6:0] src_enable;
  logic       irq_valid;
  logic [2:0] irq_index;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_level_arbiter uut (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext0_flag(ext0_flag), .tmr0_flag(tmr0_flag), .ext1_flag(ext1_flag),
    .tmr1_flag(tmr1_flag), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .tmr2_ovf_flag(tmr2_ovf_flag), .tmr2_ext_flag(tmr2_ext_flag),
    .i2c_rx_flag(i2c_rx_flag), .i2c_tx_flag(i2c_tx_flag),
    .i2c_done_flag(i2c_done_flag), .i2c_nack_flag(i2c_nack_flag),
    .src_enable(src_enable), .irq_valid(irq_valid), .irq_index(irq_index)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected winner: returns {valid, index}
  function automatic logic [3:0] model(input logic [6:0] p, input logic [6:0] pr);
    logic [6:0] grp;
    grp = ((p & pr) != 0) ? (p & pr) : p;
    for (int i = 0; i < 7; i++)
      if (grp[i]) return {1'b1, 3'(i)};
    return 4'b0;
  endfunction

  // drive raw flags for a pending pattern; variant picks which merged flag
  task automatic drive_flags(input logic [6:0] p, input int variant);
    ext0_flag     = p[0];
    tmr0_flag     = p[1];
    ext1_flag     = p[2];
    tmr1_flag     = p[3];
    ser_rx_flag   = p[4] && (variant[0] == 1'b0);             // R4 merge
    ser_tx_flag   = p[4] && (variant[0] == 1'b1);
    tmr2_ovf_flag = p[5] && (variant[1] == 1'b0);             // R4 merge
    tmr2_ext_flag = p[5] && (variant[1] == 1'b1);
    i2c_rx_flag   = p[6] && (variant % 4 == 0);               // R5 merge
    i2c_tx_flag   = p[6] && (variant % 4 == 1);
    i2c_done_flag = p[6] && (variant % 4 == 2);
    i2c_nack_flag = p[6] && (variant % 4 == 3);
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic sfr_read_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    sfr_addr = a;
    #0.5;
    check(req, sfr_rdata, exp);
  endtask

  function automatic string tag(input logic [3:0] e, input logic [6:0] p, input logic [6:0] pr);
    if (!e[3])              return "R9 idle";
    if ((p & pr) != 0)      return "R7 high level wins";
    return "R8 natural order (R4 R5 merge)";
  endfunction

  // watchdog
  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] e;
    rst_n = 1'b0; sfr_we = 1'b0; sfr_addr = 8'h00; sfr_wdata = 8'h00;
    src_enable = 7'h7F;
    drive_flags(7'h7F, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state (flags held raised during reset still resolve normally)
    drive_flags(7'h00, 0);
    @(negedge clk); @(negedge clk);
    check("R1 valid after reset", irq_valid, 0);
    sfr_read_check(8'hB8, 8'h00, "R1 base reg reset");
    sfr_read_check(8'hB9, 8'h00, "R1 ext reg reset");

    // R2 / R3 register map
    sfr_write(8'hB8, 8'hFF);
    sfr_read_check(8'hB8, 8'h3F, "R2 base reg unused bits");
    sfr_write(8'hB9, 8'hFF);
    sfr_read_check(8'hB9, 8'h01, "R3 ext reg unused bits");
    sfr_write(8'hBA, 8'h00);
    sfr_write(8'hB7, 8'h00);
    sfr_read_check(8'hB8, 8'h3F, "R3 foreign write kept base");
    sfr_read_check(8'hB9, 8'h01, "R3 foreign write kept ext");
    sfr_read_check(8'hBA, 8'h00, "R3 foreign read zero");
    sfr_write(8'hB8, 8'h15);
    sfr_read_check(8'hB8, 8'h15, "R2 base reg value");
    sfr_write(8'hB9, 8'h00);
    sfr_read_check(8'hB9, 8'h00, "R3 ext reg value");

    // R10 registered output: change request, output holds until next edge
    @(negedge clk);
    drive_flags(7'b0000010, 0);
    @(negedge clk);
    check("R10 settled idx", irq_index, 1);
    drive_flags(7'b0001000, 0);
    #0.5;
    check("R10 before edge", irq_index, 1);
    @(negedge clk);
    check("R10 after edge", irq_index, 3);

    // exhaustive priority x request sweep (R2 R3 R4 R5 R7 R8 R9)
    for (int pr = 0; pr < 128; pr++) begin
      sfr_write(8'hB8, {2'b11, 6'(pr)});
      sfr_write(8'hB9, {7'h55, 1'(pr >> 6)});
      for (int p = 0; p < 128; p++) begin
        drive_flags(7'(p), p + pr);
        @(negedge clk);
        e = model(7'(p), 7'(pr));
        check(tag(e, 7'(p), 7'(pr)), {irq_valid, irq_index}, e);
      end
    end

    // R6 enable sweep with every flag raised
    sfr_write(8'hB8, 8'h2A);
    sfr_write(8'hB9, 8'h00);
    for (int en = 0; en < 128; en++) begin
      src_enable = 7'(en);
      ext0_flag = 1; tmr0_flag = 1; ext1_flag = 1; tmr1_flag = 1;
      ser_rx_flag = 1; ser_tx_flag = 1; tmr2_ovf_flag = 1; tmr2_ext_flag = 1;
      i2c_rx_flag = 1; i2c_tx_flag = 1; i2c_done_flag = 1; i2c_nack_flag = 1;
      @(negedge clk);
      e = model(7'(en), 7'h2A);
      check("R6 enable mask", {irq_valid, irq_index}, e);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule